// File: doc/BRIEF.md
# Frame-Synchronized Pulse Output Scheduler

This block sits between a compute engine and two active-low pulse pins, one for real energy and one for reactive energy. During each multiplexer frame the engine writes a burst of pulse updates. Each update names a channel and says whether that channel should be low (pulsing) or high for one update period. The block queues the updates per channel and releases them at an even spacing. The spacing is set by a programmable interval, counted in steps of four clock cycles.

A frame-start strobe restarts the spacing counter and empties both queues. Any update that has not been released by the next frame start is thrown away and reported on a one-cycle lost-update strobe. The interval must therefore be chosen so that the last update of a frame is released before the frame ends. An 8-bit width register bounds how long a pin may stay low. When the value is 255, the bound is switched off.

Top module: `pulse_sched`

## Requirements
- R1: While reset is asserted and right after it is released, both pulse outputs are high, `upd_lost` is 0 and `ovf` is 0.
- R2: The update period is P = 4*`interval` clock cycles, and an `interval` of 0 acts as 1. The period counter restarts on the edge that samples `frame_start`. The k-th queued update reaches the pin on the clock edge k*P cycles after that edge, and the pins change on no other edge.
- R3: `upd_chan`=0 addresses the real-energy pin and `upd_chan`=1 the reactive-energy pin. The two channels are independent. `upd_low`=1 requests a low period and `upd_low`=0 a high period. When a queue is empty at a period boundary, its pin holds its level.
- R4: Each channel queues up to 8 updates and releases them in the order they were written.
- R5: A write to a channel whose queue already holds 8 entries is dropped. Such a write sets `ovf`, which then stays 1 until reset, including across frame starts.
- R6: On a `frame_start` cycle both queues are emptied, and the dropped updates never reach the pins. A write presented in that same cycle is kept as the first entry of the new frame.
- R7: `upd_lost` is 1 for exactly the one cycle after an edge where `frame_start` was sampled while either queue was non-empty. It is 0 at all other times.
- R8: If `max_width` M is not 255, a low pulse lasts at most 2*M+1 update periods. At the next period boundary the pin is forced high, even if more low updates follow.
- R9: After a pulse is clipped, the pin stays high until a high update is released. The next low update after that starts a new pulse.
- R10: If `max_width` is 255, low pulses are not limited.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame-start strobe: flushes the queues and restarts the period counter |
| upd_we | input | 1 | Update write strobe |
| upd_chan | input | 1 | Update target: 0 real, 1 reactive |
| upd_low | input | 1 | Update level: 1 low period, 0 high period |
| interval | input | 8 | Update period in units of 4 cycles (0 acts as 1) |
| max_width | input | 8 | Low-pulse limit M, giving 2*M+1 periods; 255 disables the limit |
| real_pulse_n | output | 1 | Active-low real-energy pulse |
| react_pulse_n | output | 1 | Active-low reactive-energy pulse |
| upd_lost | output | 1 | One-cycle strobe: queued updates were flushed |
| ovf | output | 1 | Sticky queue-overflow flag |

## Verification
The assertions check four things on every cycle. Pin changes happen only on period boundaries that follow the frame-start alignment. A low run never exceeds the width bound while limiting is enabled. The lost strobe always follows a frame start. The overflow flag never falls once set. Only the directed scenarios can show the rest. These include the actual level sequence of each channel, FIFO ordering, that dropped and flushed entries never reach a pin, and re-arming after a clip. They also include the interval-0 case and the two timing examples: a 1950-cycle frame with five updates, which finishes with an interval of 97 and loses its last update with 98.

// File: rtl/pulse_sched.sv
module pulse_sched #(
  parameter int DEPTH = 8,
  parameter int IW    = 8,
  parameter int MW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic          upd_we,
  input  logic          upd_chan,
  input  logic          upd_low,
  input  logic [IW-1:0] interval,
  input  logic [MW-1:0] max_width,
  output logic          real_pulse_n,
  output logic          react_pulse_n,
  output logic          upd_lost,
  output logic          ovf
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int TW = IW + 2;
  localparam int RW = MW + 1;

  logic [TW-1:0] tcnt, lim;
  logic          tick;
  logic [RW-1:0] nmax;
  logic          no_clip;
  logic [1:0]    pulse_n, flush, drop;

  assign lim     = (interval == '0) ? TW'(4) : {interval, 2'b00};
  assign tick    = !frame_start && (tcnt >= lim - TW'(1));
  assign nmax    = {max_width, 1'b1};
  assign no_clip = &max_width;

  always_ff @(posedge clk) begin
    if (!rst_n)                   tcnt <= '0;
    else if (frame_start || tick) tcnt <= '0;
    else                          tcnt <= tcnt + TW'(1);
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic [DEPTH-1:0] q, q_n;
    logic [CW-1:0]    cnt, cnt_n;
    logic             wr, pop, lvl, clip, start_hi, start_lo, cont;
    logic [RW-1:0]    run;

    assign wr       = upd_we && (upd_chan == 1'(c));
    assign pop      = tick && (cnt != '0);
    assign start_hi = pop && !q[0];
    assign start_lo = pop && q[0] && !lvl;
    assign cont     = tick && lvl && !start_hi && !start_lo;

    always_comb begin
      q_n   = q;
      cnt_n = cnt;
      if (frame_start) begin
        q_n   = '0;
        cnt_n = '0;
        if (wr) begin
          q_n[0] = upd_low;
          cnt_n  = CW'(1);
        end
      end else begin
        if (pop) begin
          q_n   = q >> 1;
          cnt_n = cnt - CW'(1);
        end
        if (wr && cnt < CW'(DEPTH)) begin
          q_n[cnt_n[AW-1:0]] = upd_low;
          cnt_n = cnt_n + CW'(1);
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q   <= '0;
        cnt <= '0;
      end else begin
        q   <= q_n;
        cnt <= cnt_n;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lvl  <= 1'b0;
        clip <= 1'b0;
        run  <= '0;
      end else if (start_hi) begin
        lvl  <= 1'b0;
        clip <= 1'b0;
        run  <= '0;
      end else if (start_lo) begin
        lvl  <= 1'b1;
        clip <= 1'b0;
        run  <= RW'(1);
      end else if (cont) begin
        if (!no_clip && run >= nmax) clip <= 1'b1;
        else if (run != '1)          run  <= run + RW'(1);
      end
    end

    assign pulse_n[c] = !(lvl && !clip);
    assign flush[c]   = frame_start && (cnt != '0);
    assign drop[c]    = wr && !frame_start && (cnt == CW'(DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_lost <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      upd_lost <= |flush;
      ovf      <= ovf | (|drop);
    end
  end

  assign real_pulse_n  = pulse_n[0];
  assign react_pulse_n = pulse_n[1];
endmodule

// File: rtl/pulse_sched_chk.sv
module pulse_sched_chk #(
  parameter int IW = 8,
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic [IW-1:0] interval,
  input logic [MW-1:0] max_width,
  input logic          real_pulse_n,
  input logic          react_pulse_n,
  input logic          upd_lost,
  input logic          ovf
);
  localparam int TW = IW + 2;
  localparam int BW = MW + 1 + TW;

  logic [TW-1:0] lim, ccnt;
  logic [BW-1:0] bound, run_r, run_x;
  logic          at_edge;

  assign lim     = (interval == '0) ? TW'(4) : {interval, 2'b00};
  assign at_edge = ccnt >= lim - TW'(1);
  assign bound   = BW'({max_width, 1'b1}) * BW'(lim);

  always_ff @(posedge clk) begin
    if (!rst_n)                      ccnt <= '0;
    else if (frame_start || at_edge) ccnt <= '0;
    else                             ccnt <= ccnt + TW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) begin
      run_r <= '0;
      run_x <= '0;
    end else begin
      run_r <= real_pulse_n  ? '0 : (run_r == '1 ? run_r : run_r + BW'(1));
      run_x <= react_pulse_n ? '0 : (run_x == '1 ? run_x : run_x + BW'(1));
    end
  end

  assert_real_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(real_pulse_n) |-> ($past(at_edge) && !$past(frame_start)));
  assert_react_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(react_pulse_n) |-> ($past(at_edge) && !$past(frame_start)));
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  assert_lost_after_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_lost |-> $past(frame_start));
  assert_real_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (max_width != '1 && !real_pulse_n) |-> run_r < bound);
  assert_react_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (max_width != '1 && !react_pulse_n) |-> run_x < bound);
endmodule

bind pulse_sched pulse_sched_chk #(.IW(IW), .MW(MW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .interval(interval),
  .max_width(max_width), .real_pulse_n(real_pulse_n), .react_pulse_n(react_pulse_n),
  .upd_lost(upd_lost), .ovf(ovf)
);

// File: tb/pulse_sched_test.sv
`timescale 1ns/1ps
module pulse_sched_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       upd_we = 1'b0;
  logic       upd_chan = 1'b0;
  logic       upd_low = 1'b0;
  logic [7:0] interval = 8'd2;
  logic [7:0] max_width = 8'd255;
  logic       real_pulse_n, react_pulse_n, upd_lost, ovf;

  int errors = 0;
  int checks = 0;
  int since = 0;

  always #2 clk = ~clk;

  pulse_sched uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .upd_we(upd_we),
    .upd_chan(upd_chan), .upd_low(upd_low), .interval(interval), .max_width(max_width),
    .real_pulse_n(real_pulse_n), .react_pulse_n(react_pulse_n),
    .upd_lost(upd_lost), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    since = 0;
  endtask

  task automatic wr(input logic ch, input logic lo);
    upd_we = 1'b1; upd_chan = ch; upd_low = lo;
    @(negedge clk);
    upd_we = 1'b0;
    since++;
  endtask

  task automatic goto_edge(input int m);
    if (m > since) begin
      repeat (m - since) @(posedge clk);
      @(negedge clk);
      since = m;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk_eq("R1 real during reset", real_pulse_n, 1);
    chk_eq("R1 react during reset", react_pulse_n, 1);
    do_reset();
    chk_eq("R1 lost after reset", upd_lost, 0);
    chk_eq("R1 ovf after reset", ovf, 0);
  endtask

  task automatic t_basic();
    interval = 8'd2; max_width = 8'd255;
    do_reset(); frame();
    wr(1'b0, 1'b1); wr(1'b1, 1'b0); wr(1'b0, 1'b0); wr(1'b1, 1'b1);
    goto_edge(7);
    chk_eq("R2 real before first boundary", real_pulse_n, 1);
    goto_edge(8);
    chk_eq("R2 real low at first boundary", real_pulse_n, 0);
    chk_eq("R3 react high from its own update", react_pulse_n, 1);
    goto_edge(15);
    chk_eq("R2 real held within period", real_pulse_n, 0);
    goto_edge(16);
    chk_eq("R4 real second entry high", real_pulse_n, 1);
    chk_eq("R4 react second entry low", react_pulse_n, 0);
    goto_edge(40);
    chk_eq("R3 react holds when queue empty", react_pulse_n, 0);
    chk_eq("R3 real holds when queue empty", real_pulse_n, 1);
  endtask

  task automatic t_interval0();
    interval = 8'd0; max_width = 8'd255;
    do_reset(); frame();
    wr(1'b1, 1'b1);
    goto_edge(3);
    chk_eq("R2 interval0 before boundary", react_pulse_n, 1);
    goto_edge(4);
    chk_eq("R2 interval0 acts as 1", react_pulse_n, 0);
  endtask

  task automatic t_clip();
    interval = 8'd1; max_width = 8'd1;
    do_reset(); frame();
    for (int i = 0; i < 5; i++) wr(1'b0, 1'b1);
    goto_edge(4);
    chk_eq("R8 pulse starts", real_pulse_n, 0);
    goto_edge(15);
    chk_eq("R8 low through third period", real_pulse_n, 0);
    goto_edge(16);
    chk_eq("R8 clipped after 3 periods", real_pulse_n, 1);
    goto_edge(24);
    chk_eq("R9 stays high despite low updates", real_pulse_n, 1);
    wr(1'b0, 1'b0); wr(1'b0, 1'b1);
    goto_edge(31);
    chk_eq("R9 high update released", real_pulse_n, 1);
    goto_edge(32);
    chk_eq("R9 new pulse after high update", real_pulse_n, 0);
    max_width = 8'd0;
    do_reset(); frame();
    wr(1'b1, 1'b1); wr(1'b1, 1'b1);
    goto_edge(4);
    chk_eq("R8 M=0 pulse starts", react_pulse_n, 0);
    goto_edge(8);
    chk_eq("R8 M=0 clipped after 1 period", react_pulse_n, 1);
  endtask

  task automatic t_noclip();
    interval = 8'd1; max_width = 8'd255;
    do_reset(); frame();
    for (int i = 0; i < 6; i++) wr(1'b0, 1'b1);
    goto_edge(4);
    chk_eq("R10 pulse starts", real_pulse_n, 0);
    goto_edge(60);
    chk_eq("R10 no limit with 255", real_pulse_n, 0);
  endtask

  task automatic t_flush();
    interval = 8'd50; max_width = 8'd255;
    do_reset(); frame();
    wr(1'b0, 1'b1); wr(1'b1, 1'b1); wr(1'b0, 1'b1);
    goto_edge(100);
    chk_eq("R7 no lost before frame", upd_lost, 0);
    frame();
    chk_eq("R7 lost strobe after flush", upd_lost, 1);
    @(negedge clk); since++;
    chk_eq("R7 lost lasts one cycle", upd_lost, 0);
    goto_edge(450);
    chk_eq("R6 flushed real never output", real_pulse_n, 1);
    chk_eq("R6 flushed react never output", react_pulse_n, 1);
    frame();
    chk_eq("R7 no lost on empty queues", upd_lost, 0);
    interval = 8'd2;
    frame_start = 1'b1; upd_we = 1'b1; upd_chan = 1'b0; upd_low = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; upd_we = 1'b0; since = 0;
    goto_edge(8);
    chk_eq("R6 write with frame start kept", real_pulse_n, 0);
  endtask

  task automatic t_ovf();
    interval = 8'd10; max_width = 8'd255;
    do_reset(); frame();
    for (int i = 0; i < 8; i++) wr(1'b0, (i % 2 == 0) ? 1'b1 : 1'b0);
    chk_eq("R5 no ovf at 8 entries", ovf, 0);
    wr(1'b0, 1'b1);
    chk_eq("R5 ovf on full write", ovf, 1);
    goto_edge(280);
    chk_eq("R4 seventh entry low", real_pulse_n, 0);
    goto_edge(320);
    chk_eq("R4 eighth entry high", real_pulse_n, 1);
    goto_edge(360);
    chk_eq("R5 dropped write not output", real_pulse_n, 1);
    frame();
    chk_eq("R5 ovf sticky across frame", ovf, 1);
  endtask

  task automatic t_frame_fit(input logic [7:0] iv, input bit expect_lost);
    interval = iv; max_width = 8'd255;
    do_reset(); frame();
    for (int i = 0; i < 5; i++) wr(1'b0, (i % 2 == 0) ? 1'b1 : 1'b0);
    goto_edge(1949);
    chk_eq("R2 fifth update state at frame end", real_pulse_n, expect_lost ? 1 : 0);
    frame();
    chk_eq("R7 lost strobe for 1950-cycle frame", upd_lost, expect_lost ? 1 : 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_interval0();
    t_clip();
    t_noclip();
    t_flush();
    t_ovf();
    t_frame_fit(8'd97, 1'b0);
    t_frame_fit(8'd98, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule